// File: doc/BRIEF.md
# Single-Channel Block-Copy DMA Engine with Burst and Cycle-Steal Modes

This block copies a contiguous run of bytes from one place in memory to another over a shared bus that it does not own. Software sets a source address, a destination address, a byte count, a transfer width and a mode, and then pulses start. The engine asks an external arbiter for the bus with a request/grant pair. Each transfer is a one-cycle read of the source followed by a one-cycle write of the same data to the destination. Both addresses then advance by the width and the remaining count drops by the width.

The mode sets how long the engine holds the bus. In burst mode it asks once and keeps the bus for the whole block, so reads and writes follow each other with no gaps. In cycle-steal mode it gives the bus back after every transfer and asks again, which lets the processor win the bus between transfers. A start with a zero count finishes at once and never touches the bus. A start with an illegal width, or with a count that is not a whole number of widths, sets an error flag and does not start.

Top module: `dma_xfer_engine`

## Requirements
- R1: Width code 2'b00 moves 1 byte, 2'b01 moves 2 bytes and 2'b10 moves 4 bytes per transfer, and `bus_size_o` carries the latched code. During a write, `bus_wdata_o` holds the low-order width bytes of the preceding read data in its low byte lanes, and all lanes above the width are zero.
- R2: Each transfer is one cycle with `bus_rd_o` high and `bus_addr_o` at the current source, then the very next cycle with `bus_wr_o` high and `bus_addr_o` at the current destination. Both addresses advance by the width after every write. A block performs count/width transfers, so the destination receives an exact copy of the source bytes and no byte past its end is changed.
- R3: `bus_rd_o` and `bus_wr_o` are high only while `bus_req_o` and `bus_gnt_i` are both high. After raising the request, the engine does not read until it has sampled the grant high.
- R4: In burst mode the request is raised once per block and held until the cycle after the last write. Every write that is not the last is followed directly by the next read.
- R5: In cycle-steal mode exactly one transfer happens per grant. After every write that is not the last, the request is low for exactly one cycle and is then raised again.
- R6: A start with a zero byte count sets `done_o` in the next cycle. The request is never raised and `busy_o` stays low.
- R7: A block of a single transfer takes the same number of busy cycles in both modes.
- R8: A start with width code 2'b11, or with a non-zero count that is not a multiple of the width, sets `err_o` in the next cycle. It raises no request and leaves `busy_o` low.
- R9: `done_o` rises in the cycle after the last write. It then stays high until `cfg_done_clr_i` is pulsed or a new start is taken while idle. A start while busy changes nothing, and an accepted start clears both `done_o` and `err_o`.
- R10: After reset, `bus_req_o`, `bus_rd_o`, `bus_wr_o`, `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_i | input | AW | Source byte address of the block |
| cfg_dst_i | input | AW | Destination byte address of the block |
| cfg_bytes_i | input | CW | Number of bytes to move |
| cfg_width_i | input | 2 | Transfer width code (00=1, 01=2, 10=4 bytes, 11 illegal) |
| cfg_mode_i | input | 1 | 0 = burst, 1 = cycle-steal |
| cfg_start_i | input | 1 | Start pulse, taken only while idle |
| cfg_done_clr_i | input | 1 | Clears the done and error flags |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_addr_o | output | AW | Byte address of the current read or write |
| bus_size_o | output | 2 | Width code of the current access |
| bus_rdata_i | input | DW | Read data, right-aligned, valid in the read cycle |
| bus_wdata_o | output | DW | Write data, right-aligned |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | Sticky completion flag |
| err_o | output | 1 | Sticky configuration-error flag |

## Verification
The hardest situation to reach from the ports is a cycle-steal block in which the arbiter keeps the engine waiting on every request. Only then do the one-cycle release, the fresh wait for a grant and the per-transfer restart all show in the cycle count. The bench's arbiter model grants after a chosen number of waiting cycles, and the stimulus sweeps that delay over long values in both modes. The bench compares the total busy cycles against closed-form counts. A second start is also pulsed mid-block with a zero count, which would finish at once if it were wrongly accepted.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } dma_state_e;

  localparam logic [1:0] WCODE_ILLEGAL = 2'b11;

  // Bytes moved per transfer for a width code; zero marks the illegal code.
  function automatic logic [2:0] wcode_bytes(input logic [1:0] code);
    case (code)
      2'b00:   wcode_bytes = 3'd1;
      2'b01:   wcode_bytes = 3'd2;
      2'b10:   wcode_bytes = 3'd4;
      default: wcode_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_start_check.sv
`timescale 1ns/1ps
// Classifies a start request: empty block, or illegal width/count (R6, R8).
module dma_start_check #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] bytes_i,
  input  logic [1:0]    wcode_i,
  output logic          zero_o,
  output logic          bad_o
);
  import dma_pkg::*;

  logic misaligned;

  always_comb begin
    misaligned = 1'b0;
    case (wcode_i)
      2'b01:   misaligned = bytes_i[0];
      2'b10:   misaligned = |bytes_i[1:0];
      default: misaligned = 1'b0;
    endcase
  end

  assign zero_o = (bytes_i == '0);
  assign bad_o  = !zero_o && ((wcode_i == WCODE_ILLEGAL) || misaligned);

endmodule

// File: rtl/dma_addr_unit.sv
`timescale 1ns/1ps
// Source, destination and remaining-count registers (R2).
module dma_addr_unit #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] bytes_i,
  input  logic [1:0]    wcode_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          last_o
);
  import dma_pkg::*;

  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] rem_q;
  logic [2:0]    stp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      stp_q <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
      rem_q <= bytes_i;
      stp_q <= wcode_bytes(wcode_i);
    end else if (step_i) begin
      src_q <= src_q + AW'(stp_q);
      dst_q <= dst_q + AW'(stp_q);
      rem_q <= rem_q - CW'(stp_q);
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign last_o = (rem_q == CW'(stp_q));

endmodule

// File: rtl/dma_data_lane.sv
`timescale 1ns/1ps
// Holds read data for the following write, clearing lanes above the width (R1).
module dma_data_lane #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic [1:0]    wcode_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wdata_o
);
  import dma_pkg::*;

  localparam int LANES = DW / 8;

  logic [3:0] keep_cnt;
  assign keep_cnt = {1'b0, wcode_bytes(wcode_i)};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (cap_i) begin
        lane_q <= (4'(g) < keep_cnt) ? rdata_i[g*8 +: 8] : 8'h00;
      end
    end
    assign wdata_o[g*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/dma_ctrl_fsm.sv
`timescale 1ns/1ps
// Request/read/write sequencing, mode latch and sticky flags (R3-R9).
module dma_ctrl_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       clr_i,
  input  logic       zero_i,
  input  logic       bad_i,
  input  logic       mode_i,
  input  logic [1:0] wcode_i,
  input  logic       gnt_i,
  input  logic       last_i,
  output logic       load_o,
  output logic       step_o,
  output logic       cap_o,
  output logic       steal_o,
  output logic [1:0] wcode_o,
  output logic       req_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  import dma_pkg::*;

  dma_state_e st_q;
  logic       steal_q;
  logic [1:0] wcode_q;
  logic       done_q;
  logic       err_q;
  logic       take;

  assign take   = (st_q == ST_IDLE) && start_i;
  assign load_o = take && !zero_i && !bad_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      steal_q <= 1'b0;
      wcode_q <= 2'b00;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (zero_i) begin
              done_q <= 1'b1;
            end else if (bad_i) begin
              err_q <= 1'b1;
            end else begin
              st_q    <= ST_REQ;
              steal_q <= mode_i;
              wcode_q <= wcode_i;
            end
          end
        end
        ST_REQ: if (gnt_i) st_q <= ST_RD;
        ST_RD:  st_q <= ST_WR;
        ST_WR: begin
          if (last_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (steal_q) begin
            st_q <= ST_GAP;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_GAP:  st_q <= ST_REQ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o    = (st_q == ST_RD);
  assign wr_o    = (st_q == ST_WR);
  assign req_o   = (st_q == ST_REQ) || rd_o || wr_o;
  assign busy_o  = (st_q != ST_IDLE);
  assign step_o  = wr_o;
  assign cap_o   = rd_o;
  assign steal_o = steal_q;
  assign wcode_o = wcode_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_bytes_i,
  input  logic [1:0]    cfg_width_i,
  input  logic          cfg_mode_i,
  input  logic          cfg_start_i,
  input  logic          cfg_done_clr_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  logic          is_zero;
  logic          is_bad;
  logic          ld;
  logic          stp;
  logic          cap;
  logic          steal_q;
  logic [1:0]    wcode_q;
  logic          xfer_last;
  logic [AW-1:0] cur_src;
  logic [AW-1:0] cur_dst;

  dma_start_check #(.CW(CW)) u_check (
    .bytes_i (cfg_bytes_i),
    .wcode_i (cfg_width_i),
    .zero_o  (is_zero),
    .bad_o   (is_bad)
  );

  dma_ctrl_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start_i (cfg_start_i),
    .clr_i   (cfg_done_clr_i),
    .zero_i  (is_zero),
    .bad_i   (is_bad),
    .mode_i  (cfg_mode_i),
    .wcode_i (cfg_width_i),
    .gnt_i   (bus_gnt_i),
    .last_i  (xfer_last),
    .load_o  (ld),
    .step_o  (stp),
    .cap_o   (cap),
    .steal_o (steal_q),
    .wcode_o (wcode_q),
    .req_o   (bus_req_o),
    .rd_o    (bus_rd_o),
    .wr_o    (bus_wr_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ld),
    .step_i  (stp),
    .src_i   (cfg_src_i),
    .dst_i   (cfg_dst_i),
    .bytes_i (cfg_bytes_i),
    .wcode_i (cfg_width_i),
    .src_o   (cur_src),
    .dst_o   (cur_dst),
    .last_o  (xfer_last)
  );

  dma_data_lane #(.DW(DW)) u_data (
    .clk     (clk),
    .rst     (rst),
    .cap_i   (cap),
    .wcode_i (wcode_q),
    .rdata_i (bus_rdata_i),
    .wdata_o (bus_wdata_o)
  );

  assign bus_addr_o = bus_rd_o ? cur_src : (bus_wr_o ? cur_dst : '0);
  assign bus_size_o = wcode_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
`timescale 1ns/1ps
module dma_xfer_engine_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          gnt,
  input logic          rd,
  input logic          wr,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          start,
  input logic          clr,
  input logic [CW-1:0] bytes,
  input logic [1:0]    width,
  input logic          steal,
  input logic          last
);

  logic cfg_bad;
  assign cfg_bad = (bytes != '0) &&
                   ((width == 2'b11) || (width == 2'b01 && bytes[0]) ||
                    (width == 2'b10 && bytes[1:0] != 2'b00));

  p_access_granted_r3: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) |-> (req && gnt));

  p_read_then_write_r2: assert property (@(posedge clk) disable iff (rst)
    rd |=> wr);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd, wr}));

  p_release_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(wr));

  p_burst_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && !steal && !last) |=> (rd && req));

  p_steal_release_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && steal) |=> !req);

  p_steal_rerequest_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && steal && !last) |=> ##1 req);

  p_zero_skips_bus_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && bytes == '0) |=> (done && !req && !busy));

  p_bad_config_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_bad) |=> (err && !req && !busy));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !clr && !(start && !busy)) |=> done);

  p_start_ignored_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !(wr && last)) |=> busy);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.CW(CW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req   (bus_req_o),
  .gnt   (bus_gnt_i),
  .rd    (bus_rd_o),
  .wr    (bus_wr_o),
  .busy  (busy_o),
  .done  (done_o),
  .err   (err_o),
  .start (cfg_start_i),
  .clr   (cfg_done_clr_i),
  .bytes (cfg_bytes_i),
  .width (cfg_width_i),
  .steal (steal_q),
  .last  (xfer_last)
);

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] bytes;
  logic [1:0]    width;
  logic          mode, start, done_clr;
  logic          bus_req, bus_gnt, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_rdata, bus_wdata;
  logic          busy, done, err;

  dma_xfer_engine #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst(rst),
    .cfg_src_i(src), .cfg_dst_i(dst), .cfg_bytes_i(bytes),
    .cfg_width_i(width), .cfg_mode_i(mode), .cfg_start_i(start),
    .cfg_done_clr_i(done_clr),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_rd_o(bus_rd),
    .bus_wr_o(bus_wr), .bus_addr_o(bus_addr), .bus_size_o(bus_size),
    .bus_rdata_i(bus_rdata), .bus_wdata_o(bus_wdata),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int nb_of(input logic [1:0] c);
    case (c)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // Arbiter: grants after gnt_delay waiting cycles, withdraws when request drops.
  int gnt_delay = 0;
  int wcnt = 0;
  always @(posedge clk) begin
    if (rst || !bus_req) begin
      bus_gnt <= 1'b0;
      wcnt    <= 0;
    end else if (!bus_gnt) begin
      if (wcnt >= gnt_delay) bus_gnt <= 1'b1;
      else wcnt <= wcnt + 1;
    end
  end

  // Byte memory, 1 KiB, little-endian lanes.
  logic [7:0] mem [1024];
  logic       init_mem;
  logic [9:0] ra;
  assign ra = bus_addr[9:0];
  assign bus_rdata = {mem[ra + 10'd3], mem[ra + 10'd2], mem[ra + 10'd1], mem[ra]};

  always @(posedge clk) begin
    if (init_mem) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (bus_wr) begin
      for (int i = 0; i < nb_of(bus_size); i++)
        mem[10'(bus_addr[9:0] + 10'(i))] <= bus_wdata[8*i +: 8];
    end
  end

  int req_cnt = 0;
  always @(posedge clk) if (bus_req) req_cnt++;

  // Behavioural reference model, updated at each rising edge.
  int          m_st = 0;     // 0 idle, 1 waiting, 2 read, 3 write, 4 released
  int          m_src = 0, m_dst = 0, m_rem = 0, m_nb = 0;
  logic        m_mode = 0, m_done = 0, m_err = 0;
  logic [1:0]  m_wcode = 0;
  logic [31:0] m_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_src = 0; m_dst = 0; m_rem = 0; m_nb = 0;
      m_mode = 0; m_done = 0; m_err = 0; m_wcode = 0; m_data = 0;
    end else begin
      if (done_clr) begin m_done = 0; m_err = 0; end
      case (m_st)
        0: if (start) begin
             m_done = 0; m_err = 0;
             if (bytes == 0) m_done = 1;
             else if (nb_of(width) == 0 || (int'(bytes) % nb_of(width)) != 0) m_err = 1;
             else begin
               m_st = 1; m_src = int'(src); m_dst = int'(dst); m_rem = int'(bytes);
               m_nb = nb_of(width); m_mode = mode; m_wcode = width;
             end
           end
        1: if (bus_gnt) m_st = 2;
        2: begin
             m_data = 0;
             for (int i = 0; i < m_nb; i++) m_data[8*i +: 8] = mem[(m_src + i) % 1024];
             m_st = 3;
           end
        3: begin
             m_rem -= m_nb; m_src += m_nb; m_dst += m_nb;
             if (m_rem == 0) begin m_st = 0; m_done = 1; end
             else m_st = m_mode ? 4 : 2;
           end
        default: m_st = 1;
      endcase
    end
  end

  logic cmp_en = 1'b0;
  always @(negedge clk) if (cmp_en) begin
    chk(bus_req == (m_st >= 1 && m_st <= 3), "R3 bus_req_o", bus_req, (m_st >= 1 && m_st <= 3));
    chk(bus_rd == (m_st == 2), "R2 bus_rd_o", bus_rd, m_st == 2);
    chk(bus_wr == (m_st == 3), "R2 bus_wr_o", bus_wr, m_st == 3);
    chk(busy == (m_st != 0), "R9 busy_o", busy, m_st != 0);
    chk(done == m_done, "R9 done_o", done, m_done);
    chk(err == m_err, "R8 err_o", err, m_err);
    if (m_st == 2) begin
      chk(bus_addr == 32'(m_src), "R2 read address", bus_addr, m_src);
      chk(bus_size == m_wcode, "R1 bus_size_o", bus_size, m_wcode);
    end
    if (m_st == 3) begin
      chk(bus_addr == 32'(m_dst), "R2 write address", bus_addr, m_dst);
      chk(bus_wdata == m_data, "R1 bus_wdata_o", bus_wdata, m_data);
    end
  end

  task automatic run(input int s, input int d, input int n, input logic [1:0] w,
                     input logic m, input int dl, output int cyc);
    gnt_delay = dl; src = AW'(s); dst = AW'(d); bytes = CW'(n); width = w; mode = m;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(posedge clk); #1;
    end
  endtask

  task automatic check_copy(input int s, input int d, input int n, input string rq);
    bit ok = 1;
    for (int i = 0; i < n; i++) if (mem[d + i] != mem[s + i]) ok = 0;
    if (mem[d + n] != pat(d + n)) ok = 0;
    chk(ok, rq, ok, 1);
  endtask

  initial begin
    int c, c2, r0;
    rst = 1; init_mem = 1; start = 0; done_clr = 0;
    src = '0; dst = '0; bytes = '0; width = '0; mode = 0;
    @(posedge clk);
    cmp_en = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0; init_mem = 0;
    @(posedge clk); #1;
    chk(!bus_req && !bus_rd && !bus_wr && !busy && !done && !err,
        "R10 reset state", {bus_req, bus_rd, bus_wr, busy, done, err}, 0);

    // Burst, 4-byte width, 4 transfers, grant after 1 wait cycle.
    run(32'h000, 32'h200, 16, 2'b10, 1'b0, 1, c);
    chk(c == 11, "R4 burst busy cycles", c, 11);
    check_copy(32'h000, 32'h200, 16, "R2 burst copy");

    // Cycle-steal, 2-byte width, 5 transfers, grant after 2 wait cycles.
    run(32'h040, 32'h240, 10, 2'b01, 1'b1, 2, c);
    chk(c == 34, "R5 steal busy cycles", c, 34);
    check_copy(32'h040, 32'h240, 10, "R2 steal copy");

    // Burst, byte width, odd addresses.
    run(32'h081, 32'h281, 7, 2'b00, 1'b0, 0, c);
    chk(c == 16, "R4 byte burst busy cycles", c, 16);
    check_copy(32'h081, 32'h281, 7, "R1 byte-wide copy");

    // Cycle-steal against a slow arbiter (processor holding the bus).
    run(32'h0A0, 32'h2C0, 12, 2'b10, 1'b1, 5, c);
    chk(c == 29, "R5 slow-grant steal cycles", c, 29);
    check_copy(32'h0A0, 32'h2C0, 12, "R2 slow-grant copy");

    // Single transfer in both modes.
    run(32'h0C0, 32'h300, 4, 2'b10, 1'b0, 3, c);
    run(32'h0C4, 32'h310, 4, 2'b10, 1'b1, 3, c2);
    chk(c == c2, "R7 single transfer equal", c, c2);
    chk(c == 7, "R7 single transfer cycles", c, 7);

    // Done holds, then clears.
    repeat (5) @(posedge clk);
    #1; chk(done, "R9 done sticky", done, 1);
    done_clr = 1; @(posedge clk); #1; done_clr = 0;
    chk(!done, "R9 done cleared", done, 0);

    // Zero count.
    r0 = req_cnt;
    run(32'h000, 32'h380, 0, 2'b10, 1'b0, 0, c);
    chk(done && c == 0 && req_cnt == r0, "R6 zero count", {done, 8'(c)}, 9'h100);

    // Misaligned count and illegal width.
    r0 = req_cnt;
    run(32'h000, 32'h380, 6, 2'b10, 1'b0, 0, c);
    chk(err && !done && c == 0 && req_cnt == r0, "R8 misaligned count", err, 1);
    check_copy(32'h3F0, 32'h380, 0, "R8 no write on misaligned");
    run(32'h000, 32'h380, 4, 2'b11, 1'b0, 0, c);
    chk(err && c == 0 && req_cnt == r0, "R8 illegal width", err, 1);
    done_clr = 1; @(posedge clk); #1; done_clr = 0;
    chk(!err, "R9 error cleared", err, 0);

    // Start while busy is ignored.
    gnt_delay = 2; src = 32'h0D0; dst = 32'h340; bytes = 8; width = 2'b01; mode = 0;
    start = 1; @(posedge clk); #1; start = 0;
    repeat (3) @(posedge clk);
    #1; bytes = 0; start = 1; @(posedge clk); #1; start = 0;
    chk(busy && !done, "R9 start ignored while busy", {busy, done}, 2'b10);
    c = 0;
    while (busy && c < 5000) begin c++; @(posedge clk); #1; end
    chk(done, "R9 done after block", done, 1);
    check_copy(32'h0D0, 32'h340, 8, "R2 copy after ignored start");

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule